// File: doc/BRIEF.md
# Reset Supervisor with Debounced Manual Reset

This block sequences the system reset for a processor subsystem. It watches two conditions. The first is a power-good flag from an external threshold comparator. The second is a raw active-low pushbutton line. While either condition calls for reset, the block holds reset. After the last active cause goes away, it keeps reset held for a fixed minimum stretch of about 250 ms. The block drives a complementary pair of reset levels. It also drives a pull-low enable, so that an external pad cell can build the open-drain stage of the active-low reset.

Both inputs pass through a two-flop synchroniser. The button then goes through a debounce filter. The filter accepts a new level only after the level has held for about 20 ms without a break. Any return to the old level restarts the count, so bounce and short glitches never count as a press. All timing is derived from parameters: the clock rate in Hz, the debounce time in ms and the stretch time in ms. A bench can therefore shrink the intervals by lowering the clock-rate parameter.

Top module: `rst_supervisor`

## Requirements
- R1: `rst_n_o` is always the logical inverse of `rst_o`.
- R2: `rst_n_pull_o` is 1 exactly when the active-low reset is asserted, so it always equals `rst_o`.
- R3: When `pwr_good_i` is 0 for three consecutive clock edges, `rst_o` is 1 from the following cycle.
- R4: After the last cause clears, `rst_o` stays 1 for at least STRETCH_MS·CLK_HZ/1000 cycles. It drops within that count plus 4 cycles once `pwr_good_i` has returned to 1.
- R5: If `pb_n_i` stays 0 for DEBOUNCE_MS·CLK_HZ/1000 cycles, the press is accepted and `rst_o` goes to 1 within 4 further cycles. This holds whatever the value of `pwr_good_i`.
- R6: A low pulse on `pb_n_i` shorter than the debounce count leaves `rst_o` at 0.
- R7: After an accepted press ends, `rst_o` stays 1 for at least the stretch count, starting from the debounced release. It drops within one debounce count plus the stretch count plus 4 cycles.
- R8: Bounce made of low stretches shorter than the debounce count, broken by single high cycles, never asserts reset, however long it lasts.
- R9: During `arst_n` = 0, `rst_o` is 1. After release with no cause active, `rst_o` stays 1 for the stretch count and then drops. A `pb_n_i` held at 1 is read as not pressed.
- R10: If a cause reappears during the stretch, the stretch restarts in full from the new cause's release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block's own logic |
| pwr_good_i | input | 1 | Supply-above-trip flag from the comparator, 1 = good (asynchronous) |
| pb_n_i | input | 1 | Raw pushbutton line, 0 = pressed (asynchronous) |
| rst_o | output | 1 | Active-high system reset |
| rst_n_o | output | 1 | Active-low system reset level |
| rst_n_pull_o | output | 1 | Pull-low enable for an external open-drain reset pad |

## Verification
Most internal faults in this block show up as timing faults at the reset outputs, not as wrong levels.

- A debounce counter that fails to restart, or that starts from the wrong count, lets bounce through as a reset. It can also accept a press several cycles early or late, which is visible within one debounce interval of the stimulus.
- A stretch counter that fails to reload, or that loads the wrong value, moves the falling edge of `rst_o`. That edge is checked against both a lower and an upper bound, so the error is caught one stretch interval after the last cause clears.
- A broken output pairing breaks the complement of `rst_o` and `rst_n_o` in the same cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Reset causes gathered ahead of the stretch timer.
    typedef struct packed {
        logic pwr_fail;
        logic button;
    } cause_t;

    // Converts a duration in ms at a clock rate in Hz into a cycle count (minimum 1).
    function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
        longint unsigned prod;
        prod = (longint'(clk_hz) * longint'(ms)) / 64'd1000;
        if (prod == 0) prod = 1;
        return int'(prod);
    endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
    parameter int unsigned CYC = 1_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lvl_n_i,     // synchronised button level, 0 = pressed
    output logic pressed_o
);

    localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC - 1);

    typedef struct packed {
        logic             filt;   // accepted level, 1 = released
        logic [CNT_W-1:0] cnt;    // consecutive cycles at the opposite level
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_n_i == st_q.filt) begin
            // Any return to the accepted level restarts the run.
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.filt = lvl_n_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.filt <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pressed_o = ~st_q.filt;

endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
    import rsv_pkg::*;
#(
    parameter int unsigned CYC = 12_500_000
) (
    input  logic   clk,
    input  logic   arst_n,
    input  cause_t cause_i,
    output logic   rst_o
);

    localparam int unsigned CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CYC);

    typedef struct packed {
        logic             rst;
        logic [CNT_W-1:0] cnt;    // remaining hold cycles
    } str_state_t;

    str_state_t st_d, st_q;
    logic       any_cause;

    always_comb begin
        any_cause = |cause_i;
        st_d      = st_q;
        if (any_cause) begin
            st_d.cnt = CNT_FULL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.rst = any_cause || (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.rst <= 1'b1;
            st_q.cnt <= CNT_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o = st_q.rst;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned DEBOUNCE_MS = 20,
    parameter int unsigned STRETCH_MS  = 250
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_good_i,
    input  logic pb_n_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic rst_n_pull_o
);

    localparam int unsigned DB_CYC = ms_to_cycles(CLK_HZ, DEBOUNCE_MS);
    localparam int unsigned ST_CYC = ms_to_cycles(CLK_HZ, STRETCH_MS);

    logic [1:0] raw_in;
    logic [1:0] syn_in;
    logic       pressed;
    cause_t     cause;
    logic       cause_any;
    logic       rst_int;

    assign raw_in = {pwr_good_i, pb_n_i};

    // Power-bad and released-button are the safe reset values.
    rsv_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) i_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    rsv_debounce #(
        .CYC (DB_CYC)
    ) i_debounce (
        .clk       (clk),
        .arst_n    (arst_n),
        .lvl_n_i   (syn_in[0]),
        .pressed_o (pressed)
    );

    always_comb begin
        cause.pwr_fail = ~syn_in[1];
        cause.button   = pressed;
        cause_any      = |cause;
    end

    rsv_stretch #(
        .CYC (ST_CYC)
    ) i_stretch (
        .clk     (clk),
        .arst_n  (arst_n),
        .cause_i (cause),
        .rst_o   (rst_int)
    );

    assign rst_o        = rst_int;
    assign rst_n_o      = ~rst_int;
    assign rst_n_pull_o = rst_int;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int unsigned ST_CYC = 100
) (
    input logic clk,
    input logic arst_n,
    input logic pwr_good_i,
    input logic cause_any,
    input logic rst_o,
    input logic rst_n_o,
    input logic rst_n_pull_o
);

    int unsigned quiet_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          quiet_q <= 0;
        else if (cause_any)   quiet_q <= 0;
        else if (quiet_q < ST_CYC) quiet_q <= quiet_q + 1;
    end

    AST_PAIR_INVERSE: assert property (@(posedge clk) disable iff (!arst_n)
        rst_n_o == !rst_o);                                          // R1

    AST_PULL_MATCH: assert property (@(posedge clk) disable iff (!arst_n)
        rst_n_pull_o == !rst_n_o);                                   // R2

    AST_PWR_BAD_RESET: assert property (@(posedge clk) disable iff (!arst_n)
        (!pwr_good_i && !$past(pwr_good_i) && !$past(pwr_good_i, 2)) |=> rst_o); // R3

    AST_MIN_STRETCH: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_o) |-> (quiet_q >= ST_CYC));                       // R4

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
        cause_any |=> rst_o);                                        // R5

endmodule

bind rst_supervisor rst_supervisor_chk #(
    .ST_CYC (ST_CYC)
) i_rst_supervisor_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .pwr_good_i   (pwr_good_i),
    .cause_any    (cause_any),
    .rst_o        (rst_o),
    .rst_n_o      (rst_n_o),
    .rst_n_pull_o (rst_n_pull_o)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

    // 400 Hz nominal rate: debounce = 8 cycles, stretch = 100 cycles.
    localparam int unsigned TB_HZ = 400;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic pwr_good_i = 1'b1;
    logic pb_n_i = 1'b1;
    logic rst_o, rst_n_o, rst_n_pull_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    rst_supervisor #(
        .CLK_HZ      (TB_HZ),
        .DEBOUNCE_MS (20),
        .STRETCH_MS  (250)
    ) i_rst_supervisor (
        .clk          (clk),
        .arst_n       (arst_n),
        .pwr_good_i   (pwr_good_i),
        .pb_n_i       (pb_n_i),
        .rst_o        (rst_o),
        .rst_n_o      (rst_n_o),
        .rst_n_pull_o (rst_n_pull_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pair();
        check("R1", rst_n_o, ~rst_o);
        check("R2", rst_n_pull_o, rst_o);
    endtask

    // Vector fields: [15] pwr_good, [14] pb_n, [13] expected rst_o, [12:0] hold cycles
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 13'd60},   // R9 still in power-on stretch
        {1'b1, 1'b1, 1'b0, 13'd50},   // R9 stretch ended
        {1'b1, 1'b0, 1'b0, 13'd5},    // R6 short low pulse
        {1'b1, 1'b1, 1'b0, 13'd20},   // R6 no reset afterwards
        {1'b1, 1'b0, 1'b1, 13'd14},   // R5 held press accepted
        {1'b1, 1'b1, 1'b1, 13'd98},   // R7 still stretching after release
        {1'b1, 1'b1, 1'b0, 13'd25},   // R7 released in time
        {1'b0, 1'b1, 1'b1, 13'd4},    // R3 power bad
        {1'b1, 1'b1, 1'b1, 13'd98},   // R4 held after power good
        {1'b1, 1'b1, 1'b0, 13'd10},   // R4 released in time
        {1'b0, 1'b0, 1'b1, 13'd12},   // R5 both causes
        {1'b1, 1'b0, 1'b1, 13'd30},   // R5 press alone keeps reset
        {1'b1, 1'b1, 1'b0, 13'd125}   // R7 final release
    };

    initial begin : watchdog
        repeat (200_000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic saw_rst;
        repeat (3) @(negedge clk);
        check("R9", rst_o, 1'b1);          // asserted during reset
        check_pair();
        arst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pwr_good_i = VEC[i][15];
            pb_n_i     = VEC[i][14];
            repeat (int'(VEC[i][12:0])) @(negedge clk);
            check($sformatf("vector %0d R3-R9", i), rst_o, VEC[i][13]);
            check_pair();
        end

        // R8: bounce never held for the debounce count
        saw_rst = 1'b0;
        for (int k = 0; k < 12; k++) begin
            pb_n_i = 1'b0;
            repeat (6) begin @(negedge clk); saw_rst |= rst_o; end
            pb_n_i = 1'b1;
            @(negedge clk); saw_rst |= rst_o;
        end
        repeat (20) begin @(negedge clk); saw_rst |= rst_o; end
        check("R8 bounce", saw_rst, 1'b0);

        // R10: second power dip during stretch restarts it
        pwr_good_i = 1'b0;
        repeat (4) @(negedge clk);
        pwr_good_i = 1'b1;
        repeat (60) @(negedge clk);
        check("R10 mid-stretch", rst_o, 1'b1);
        pwr_good_i = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good_i = 1'b1;
        repeat (80) @(negedge clk);
        check("R10 restarted stretch", rst_o, 1'b1);
        repeat (30) @(negedge clk);
        check("R10 final release", rst_o, 1'b0);
        check_pair();

        // R9: async reset mid-run reasserts and restretches
        arst_n = 1'b0;
        #3;
        check("R9 async assert", rst_o, 1'b1);
        @(negedge clk);
        arst_n = 1'b1;
        repeat (90) @(negedge clk);
        check("R9 post-reset stretch", rst_o, 1'b1);
        repeat (20) @(negedge clk);
        check("R9 post-reset release", rst_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule